// File: doc/BRIEF.md
# Baseband Hang Watchdog Timer

This block watches a radio baseband for a stuck state. A prescaler divides the baseband clock into coarse ticks of 2^TICK_LOG2 clocks; 2^15 is the default. A timeout counter counts those ticks. Each of the baseband's two modes, active (non-idle) and idle, has its own enable and its own tick limit. The counter starts again from zero when software reads the status word, when the baseband moves between idle and active, and while the mode it is in has its enable clear.

When the limit is reached, a hang flag is set. In the same clock edge, a snapshot of the baseband's seven sub-state-machine state fields is latched, together with a code naming the mode that timed out. The snapshot then stays frozen until software clears the flag. The timeout can drive a level interrupt, which is also mirrored into bit 16 of a secondary interrupt status word. It can also drive a one-cycle chip-reset request. Either, both or neither may be enabled.

Software reaches the block through a synchronous single-cycle register port with three words: status, control 1 and control 2.

Top module: `bb_hang_wdt`

## Requirements
- R1: After reset, the status word, control 1 and control 2 all read 0, and `wdt_irq`, `wdt_rst_req` and `sec_isr` are low.
- R2: In active mode (`bb_idle`=0), with control 1 bit 0 set and a non-idle limit N≠0 in control 1 bits [15:2], the hang flag rises exactly N·2^TICK_LOG2 clock edges after the last restart edge.
- R3: In idle mode (`bb_idle`=1), with control 1 bit 1 set and an idle limit N≠0 in control 1 bits [31:16], the hang flag rises exactly N·2^TICK_LOG2 edges after the last restart edge. The non-idle limit is not used in this mode.
- R4: While the enable for the current mode is clear, or the limit for that mode is 0, the hang flag never rises.
- R5: These events are restart edges: an edge that samples a status read, and an edge that samples a changed `bb_idle`. The tick count starts again from zero at a restart edge.
- R6: On expiry, the status word becomes `{bb_fsm_st[27:0], 1, info}`. Field i of `bb_fsm_st` (bits 4i+3:4i) lands in status bits 4i+7:4i+4. The info code is 3'b001 for an active-mode expiry and 3'b010 for an idle-mode expiry. The snapshot does not change while the flag stays set, even when `bb_fsm_st` changes.
- R7: A status write with data bit 3 = 0 clears the whole status word to 0. A status write with bit 3 = 1 has no effect. While the flag is set, the count is held at zero, so the clearing edge acts as a restart edge.
- R8: `wdt_irq` is high exactly while the hang flag is set and control 2 bit 2 is set. `sec_isr` equals `wdt_irq` placed in bit 16, with all other bits 0.
- R9: When control 2 bit 1 is set, `wdt_rst_req` is high for exactly one cycle, on the edge where the hang flag rises. Otherwise it stays low.
- R10: Word address 0 is status, 1 is control 1, 2 is control 2, and 3 reads 0. Read data appears on the edge that samples `reg_rd`. Control 1 and control 2 store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Baseband clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bb_idle | input | 1 | Baseband mode: 1 idle, 0 active |
| bb_fsm_st | input | 28 | Seven 4-bit sub-state-machine states: radar, rx OFDM, rx CCK, tx OFDM, tx CCK, AGC, search (LSB first) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| wdt_irq | output | 1 | Level interrupt on hang |
| wdt_rst_req | output | 1 | One-cycle chip-reset request |
| sec_isr | output | 32 | Secondary interrupt status word, hang interrupt at bit 16 |

## Verification
The assertions assume a register write that sets the enables is not sampled on the same edge as a status clear of a pending expiry. They also assume `bb_idle` is a synchronous level that is stable around each edge. The stimulus drives every input half a cycle away from the sampling edge. It changes control words only while no expiry is pending, and it holds `bb_idle` steady through each timed window, except for the deliberate mode switch. With a 3-bit prescaler, expected expiry cycles come from N·8 counted from each restart edge.

// File: rtl/bb_wdt_pkg.sv
package bb_wdt_pkg;
   localparam int REG_W    = 32;
   localparam int FLD_W    = 4;
   localparam int NUM_FLD  = 7;
   localparam int FSM_W    = FLD_W * NUM_FLD;
   localparam int INFO_W   = 3;
   localparam int NIDL_LSB = 2;
   localparam int NIDL_W   = 14;
   localparam int IDL_LSB  = 16;
   localparam int IDL_W    = 16;
   localparam int CNT_W    = (IDL_W > NIDL_W) ? IDL_W : NIDL_W;
   localparam int EN_NIDL  = 0;
   localparam int EN_IDL   = 1;
   localparam int EN_RST   = 1;
   localparam int EN_IRQ   = 2;
   localparam int HANG_BIT = 3;
   localparam int ISR_BIT  = 16;

   typedef enum logic [1:0] {
      WA_STATUS = 2'd0,
      WA_CTRL1  = 2'd1,
      WA_CTRL2  = 2'd2,
      WA_NONE   = 2'd3
   } wdt_addr_e;

   localparam logic [INFO_W-1:0] INFO_ACTIVE = 3'b001;
   localparam logic [INFO_W-1:0] INFO_IDLE   = 3'b010;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int TICK_LOG2 = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);
   logic [TICK_LOG2-1:0] pre_q;

   assign tick = &pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_q <= '0;
      else if (restart) pre_q <= '0;
      else              pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/wdt_timeout_ctr.sv
module wdt_timeout_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic             enable,
   input  logic [CNT_W-1:0] limit,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;

   assign expire = enable && (limit != '0) && tick && !restart &&
                   (cnt_q == limit - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (restart || !enable) cnt_q <= '0;
      else if (expire)             cnt_q <= '0;
      else if (tick)               cnt_q <= cnt_q + ONE;
   end
endmodule

// File: rtl/wdt_status_cap.sv
module wdt_status_cap
   import bb_wdt_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              clr,
   input  logic [INFO_W-1:0] info_in,
   input  logic [FSM_W-1:0]  fsm_in,
   output logic              hang,
   output logic [INFO_W-1:0] info,
   output logic [FSM_W-1:0]  fields
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hang <= 1'b0;
         info <= '0;
      end else if (capture) begin
         hang <= 1'b1;
         info <= info_in;
      end else if (clr) begin
         hang <= 1'b0;
         info <= '0;
      end
   end

   for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
      logic [FLD_W-1:0] f_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       f_q <= '0;
         else if (capture) f_q <= fsm_in[i*FLD_W +: FLD_W];
         else if (clr)     f_q <= '0;
      end
      assign fields[i*FLD_W +: FLD_W] = f_q;
   end
endmodule

// File: rtl/bb_hang_wdt.sv
module bb_hang_wdt
   import bb_wdt_pkg::*;
#(
   parameter int TICK_LOG2 = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bb_idle,
   input  logic [FSM_W-1:0]  bb_fsm_st,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [1:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              wdt_irq,
   output logic              wdt_rst_req,
   output logic [REG_W-1:0]  sec_isr
);
   if (TICK_LOG2 < 1 || TICK_LOG2 > 24) begin : g_bad_tick
      $error("bb_hang_wdt: TICK_LOG2 must lie in 1..24");
   end
   if (FSM_W + INFO_W + 1 != REG_W) begin : g_bad_layout
      $error("bb_hang_wdt: status layout does not fill the word");
   end

   logic [REG_W-1:0]  ctrl1_q, ctrl2_q;
   logic              idle_q;
   logic              hang, tick, expire, mode_chg, stat_rd, stat_clr;
   logic              cur_en, restart;
   logic [CNT_W-1:0]  cur_limit;
   logic [INFO_W-1:0] snap_info, cur_info;
   logic [FSM_W-1:0]  snap_fields;
   logic [REG_W-1:0]  status_w;

   assign mode_chg = bb_idle ^ idle_q;
   assign stat_rd  = reg_rd && (wdt_addr_e'(reg_addr) == WA_STATUS);
   assign stat_clr = reg_wr && (wdt_addr_e'(reg_addr) == WA_STATUS) &&
                     !reg_wdata[HANG_BIT];

   always_comb begin
      if (bb_idle) begin
         cur_en    = ctrl1_q[EN_IDL];
         cur_limit = CNT_W'(ctrl1_q[IDL_LSB +: IDL_W]);
         cur_info  = INFO_IDLE;
      end else begin
         cur_en    = ctrl1_q[EN_NIDL];
         cur_limit = CNT_W'(ctrl1_q[NIDL_LSB +: NIDL_W]);
         cur_info  = INFO_ACTIVE;
      end
   end

   assign restart = stat_rd || mode_chg || hang || !cur_en;

   wdt_tick_gen #(.TICK_LOG2(TICK_LOG2)) tick_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   wdt_timeout_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick),
      .enable  (cur_en),
      .limit   (cur_limit),
      .expire  (expire)
   );

   wdt_status_cap cap_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (expire),
      .clr     (stat_clr),
      .info_in (cur_info),
      .fsm_in  (bb_fsm_st),
      .hang    (hang),
      .info    (snap_info),
      .fields  (snap_fields)
   );

   assign status_w = {snap_fields, hang, snap_info};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl1_q     <= '0;
         ctrl2_q     <= '0;
         idle_q      <= 1'b0;
         reg_rdata   <= '0;
         wdt_rst_req <= 1'b0;
      end else begin
         idle_q      <= bb_idle;
         wdt_rst_req <= expire && ctrl2_q[EN_RST];
         if (reg_wr) begin
            case (wdt_addr_e'(reg_addr))
               WA_CTRL1: ctrl1_q <= reg_wdata;
               WA_CTRL2: ctrl2_q <= reg_wdata;
               default:  ;
            endcase
         end
         if (reg_rd) begin
            case (wdt_addr_e'(reg_addr))
               WA_STATUS: reg_rdata <= status_w;
               WA_CTRL1:  reg_rdata <= ctrl1_q;
               WA_CTRL2:  reg_rdata <= ctrl2_q;
               default:   reg_rdata <= '0;
            endcase
         end
      end
   end

   assign wdt_irq = hang && ctrl2_q[EN_IRQ];
   assign sec_isr = REG_W'(wdt_irq) << ISR_BIT;
endmodule

// File: rtl/bb_hang_wdt_chk.sv
module bb_hang_wdt_chk
   import bb_wdt_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_en,
   input logic             hang,
   input logic [FSM_W-1:0] fields,
   input logic             tick,
   input logic             rst_req,
   input logic             irq
);
   // R4: with both mode enables clear the flag cannot rise next cycle
   assert_disabled_never_fires_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en == 2'b00) |=> !$rose(hang));

   // R2: a new hang is always caused by a prescaler tick
   assert_expiry_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hang) |-> $past(tick));

   // R6: the snapshot stays frozen while the flag holds
   assert_snapshot_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hang && $past(hang)) |-> $stable(fields));

   // R9: reset request is a lone pulse aligned with the flag rising
   assert_rst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   assert_rst_at_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $rose(hang));

   // R8: the interrupt never stands without the hang flag
   assert_irq_needs_hang_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> hang);
endmodule

bind bb_hang_wdt bb_hang_wdt_chk chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_en (ctrl1_q[1:0]),
   .hang    (hang),
   .fields  (snap_fields),
   .tick    (tick),
   .rst_req (wdt_rst_req),
   .irq     (wdt_irq)
);

// File: tb/bb_hang_wdt_tb_top.sv
`timescale 1ns/1ps
module bb_hang_wdt_tb_top;
   localparam int TL2 = 3;
   localparam int TP  = 1 << TL2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bb_idle = 1'b0;
   logic [27:0] bb_fsm_st = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        wdt_irq, wdt_rst_req;
   logic [31:0] sec_isr;

   int nchk = 0;
   int nfail = 0;

   always #2.5 clk = ~clk;

   bb_hang_wdt #(.TICK_LOG2(TL2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bb_idle(bb_idle), .bb_fsm_st(bb_fsm_st),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wdt_irq(wdt_irq),
      .wdt_rst_req(wdt_rst_req), .sec_isr(sec_isr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
      reg_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // Called right after a restart edge; checks irq/rst/sec_isr each cycle.
   task automatic wait_expect(input int n, input bit ren, input bit ien,
                              input string req);
      int bad = 0;
      logic [31:0] act = '0, exp = '0;
      for (int k = 1; k <= n*TP + 3; k++) begin
         logic ei, er;
         @(negedge clk);
         ei = ien && (k >= n*TP);
         er = ren && (k == n*TP);
         if (wdt_irq !== ei || wdt_rst_req !== er ||
             sec_isr !== (32'(ei) << 16)) begin
            if (bad == 0) begin
               act = {sec_isr[31:2], wdt_rst_req, wdt_irq};
               exp = {32'(ei) << 16} | {30'd0, er, ei};
               exp[1:0] = {er, ei};
            end
            bad++;
         end
      end
      chk(bad == 0, req, $sformatf("expiry timing for %0d ticks", n), act, exp);
   endtask

   task automatic quiet(input int cyc, input string req, input string what);
      int bad = 0;
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk);
         if (wdt_irq !== 1'b0 || wdt_rst_req !== 1'b0) bad++;
      end
      chk(bad == 0, req, what, 32'(bad), 32'd0);
   endtask

   task automatic run_tests();
      logic [31:0] d, snap;
      logic [27:0] pat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(wdt_irq === 1'b0 && wdt_rst_req === 1'b0 && sec_isr === 32'd0,
          "R1", "outputs after reset", {wdt_irq, wdt_rst_req}, 32'd0);
      rd(2'd0, d); chk(d === 32'd0, "R1", "status after reset", d, 32'd0);
      rd(2'd1, d); chk(d === 32'd0, "R1", "ctrl1 after reset", d, 32'd0);
      rd(2'd2, d); chk(d === 32'd0, "R1", "ctrl2 after reset", d, 32'd0);

      // R10 register storage and address map
      wr(2'd2, 32'hA5A5_5A58); rd(2'd2, d);
      chk(d === 32'hA5A5_5A58, "R10", "ctrl2 storage", d, 32'hA5A5_5A58);
      wr(2'd1, 32'h0000_FFFC); rd(2'd1, d);
      chk(d === 32'h0000_FFFC, "R10", "ctrl1 storage", d, 32'h0000_FFFC);
      rd(2'd3, d); chk(d === 32'd0, "R10", "address 3 reads zero", d, 32'd0);

      // R4 disabled modes and zero limits
      wr(2'd2, 32'h0000_0006);
      wr(2'd1, 32'hFFFF_FFFC);
      quiet(200, "R4", "no fire with both enables clear");
      wr(2'd1, 32'h0000_0003);
      quiet(200, "R4", "no fire with zero active limit");
      bb_idle = 1'b1;
      quiet(200, "R4", "no fire with zero idle limit");
      rd(2'd0, d); chk(d === 32'd0, "R4", "status stays clear", d, 32'd0);
      bb_idle = 1'b0;
      @(negedge clk);

      // R2 sweep in active mode, rst enable alternating, irq enabled
      for (int n = 1; n <= 6; n++) begin
         bit ren = n[0];
         pat = 28'h1234567 + 28'(n) * 28'h0111111;
         bb_fsm_st = pat;
         wr(2'd2, {29'd0, 1'b1, ren, 1'b0});
         wr(2'd1, (32'(n) << 2) | (32'(n + 9) << 16) | 32'd1);
         rd(2'd0, d);
         wait_expect(n, ren, 1'b1, "R2");
         rd(2'd0, d);
         chk(d === {pat, 1'b1, 3'b001}, "R6", "active snapshot", d, {pat, 1'b1, 3'b001});
         wr(2'd0, 32'd0);
         rd(2'd0, d); chk(d === 32'd0, "R7", "status cleared", d, 32'd0);
      end

      // R3 sweep in idle mode, both enables set, different active limit
      bb_idle = 1'b1;
      @(negedge clk);
      for (int n = 1; n <= 5; n++) begin
         pat = 28'hFEDCBA9 - 28'(n) * 28'h0101010;
         bb_fsm_st = pat;
         wr(2'd2, 32'h0000_0006);
         wr(2'd1, (32'(n) << 16) | (32'(n + 3) << 2) | 32'd3);
         rd(2'd0, d);
         wait_expect(n, 1'b1, 1'b1, "R3");
         rd(2'd0, d);
         chk(d === {pat, 1'b1, 3'b010}, "R6", "idle snapshot", d, {pat, 1'b1, 3'b010});
         wr(2'd0, 32'd0);
      end

      // R6 snapshot frozen, R7 bit3=1 write ignored, count held while flagged
      wr(2'd1, (32'd2 << 16) | 32'd2);
      wr(2'd2, 32'h0000_0004);
      pat = 28'h0A0B0C0;
      bb_fsm_st = pat;
      rd(2'd0, d);
      wait_expect(2, 1'b0, 1'b1, "R3");
      bb_fsm_st = 28'h5555555;
      repeat (40) @(negedge clk);
      rd(2'd0, snap);
      chk(snap === {pat, 1'b1, 3'b010}, "R6", "snapshot frozen", snap, {pat, 1'b1, 3'b010});
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d); chk(d === snap, "R7", "bit3=1 write ignored", d, snap);
      chk(wdt_irq === 1'b1, "R8", "irq level holds", 32'(wdt_irq), 32'd1);
      wr(2'd0, 32'h0000_0000);
      wait_expect(2, 1'b0, 1'b1, "R7");

      // R8 irq disabled: no irq, flag still set
      wr(2'd0, 32'd0);
      wr(2'd2, 32'h0000_0000);
      rd(2'd0, d);
      wait_expect(2, 1'b0, 1'b0, "R8");
      rd(2'd0, d);
      chk(d[3] === 1'b1, "R8", "hang set without irq", 32'(d[3]), 32'd1);
      wr(2'd2, 32'h0000_0004);
      @(negedge clk);
      chk(wdt_irq === 1'b1 && sec_isr === 32'h0001_0000, "R8",
          "irq follows enable", sec_isr, 32'h0001_0000);
      wr(2'd0, 32'd0);

      // R5 read restart and mode-change restart
      bb_idle = 1'b0;
      wr(2'd1, (32'd2 << 16) | (32'd3 << 2) | 32'd3);
      rd(2'd0, d);
      repeat (20) @(negedge clk);
      rd(2'd0, d);
      wait_expect(3, 1'b0, 1'b1, "R5");
      wr(2'd0, 32'd0);
      rd(2'd0, d);
      repeat (20) @(negedge clk);
      bb_idle = 1'b1;
      @(negedge clk);
      wait_expect(2, 1'b0, 1'b1, "R5");
      rd(2'd0, d);
      chk(d[2:0] === 3'b010, "R5", "mode-change expiry in idle", 32'(d[2:0]), 32'd2);
      wr(2'd0, 32'd0);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (100000) @(posedge clk);
            nchk++; nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule